// File: doc/BRIEF.md
# Subroutine Return Stack Engine

This block keeps the return-address stack of a small 8-bit controller core in the core's internal data RAM. It owns the 8-bit status word. The upper four bits of that word are flags: carry, auxiliary carry, a user flag and the register-bank select. Bit 3 is a constant one. The lower three bits form the stack pointer. On a call or an interrupt entry, the block writes a two-byte frame into RAM and advances the pointer. A frame holds the low eight bits of the 12-bit program counter, plus the four flags packed beside the high four program-counter bits.

A return pulls the pointer back and reads the frame, high byte first and then low byte, through the same single-port RAM. It then presents the restored 12-bit program counter with a one-cycle done strobe. There are two return flavours: one also puts the saved flags back into the status word, and the other leaves them alone. The pointer is three bits wide, so a ninth nested push wraps it and quietly overwrites the oldest frame. The core can also load the status word directly while the engine is idle. The RAM has a one-cycle read latency: data addressed in one cycle appears on `ram_rdata` in the next.

Top module: `callret_stack`

## Requirements
- R1: After reset `status_out` is 0x08 (flags clear, pointer 0), `ready` is 1, and `done`, `ram_we` and `ram_re` are 0.
- R2: Bit 3 of `status_out` is 1 in every cycle.
- R3: While `ready` is 1 and no request is raised, `sts_we` loads bits 7:4 and 2:0 of `sts_wdata` into the status word on the next edge; bit 3 of `sts_wdata` has no effect.
- R4: A call accepted in cycle 0 writes PC[7:0] to address 0x08+2·ptr in cycle 1. It then writes {status[7:4], PC[11:8]} to 0x09+2·ptr in cycle 2. Here ptr is the pointer at acceptance.
- R5: After a push the pointer is one higher, visible in cycle 3 together with a one-cycle `done` pulse.
- R6: The flag nibble stored in a frame is the one present in the status word when the call was accepted.
- R7: A push with pointer 7 uses addresses 0x16/0x17 and leaves the pointer at 0. The next push writes over addresses 0x08/0x09, and no error indication exists.
- R8: A return accepted in cycle 0 lowers the pointer at once. It reads 0x09+2·ptr in cycle 1 and 0x08+2·ptr in cycle 2, with ptr the lowered value. In cycle 4 it raises `done`, with `pc_out` = {high[3:0], low[7:0]}.
- R9: `ret_flags_req` copies high[7:4] of the frame into status bits 7:4, visible with `done`. `ret_plain_req` leaves status bits 7:4 unchanged.
- R10: `ready` is 0 from the cycle after acceptance until the operation ends. Requests and status writes raised during that time are ignored.
- R11: `call_req` has priority over a return request raised in the same cycle. The call is the only operation performed.
- R12: Every RAM access addresses 0x08 through 0x17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_req | input | 1 | Push a frame (call or interrupt entry) |
| ret_plain_req | input | 1 | Return, program counter only |
| ret_flags_req | input | 1 | Return, program counter and flags |
| pc_in | input | 12 | Program counter to save on a push |
| sts_we | input | 1 | Load the status word |
| sts_wdata | input | 8 | Value for the status load |
| status_out | output | 8 | Current status word |
| ready | output | 1 | Engine idle, can accept a request |
| done | output | 1 | One-cycle end-of-operation strobe |
| pc_out | output | 12 | Restored program counter, valid with done after a return |
| ram_addr | output | 8 | RAM address |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after the read strobe |

## Verification
A wrong pointer shows up at once in the low bits of `status_out`. It also shows on the next RAM address, one cycle after the following request is accepted. A misordered or mispacked frame stays hidden while it sits in RAM. It only appears when the matching return puts a wrong `pc_out` or wrong flags on the ports four cycles after acceptance, which can be many operations later. The tests therefore check every write as it happens and pair each push with a later return. A sequencer that forgets to clear its busy state shows within a cycle through `ready` and a stray `done`.

// File: rtl/callret_pkg.sv
// Shared types for the return-stack engine.
// Assumes nothing beyond IEEE 1800-2017 enums.
package callret_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_RD_HI,
        ST_RD_LO,
        ST_RD_FIN
    } seq_state_t;
endpackage

// File: rtl/cs_frame_addr.sv
// Maps a stack pointer to the two RAM addresses of its frame.
// Assumes frames are two bytes wide and packed upward from STACK_BASE.
module cs_frame_addr #(
    parameter int          ADDR_W     = 8,
    parameter int          PTR_W      = 3,
    parameter logic [7:0]  STACK_BASE = 8'h08
) (
    input  logic [PTR_W-1:0]  ptr,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [ADDR_W-1:0] hi_addr
);
    // Frame offset is twice the pointer; the high byte sits one above.
    always_comb begin
        lo_addr = ADDR_W'(STACK_BASE) + ADDR_W'({ptr, 1'b0});
        hi_addr = lo_addr + ADDR_W'(1);
    end
endmodule

// File: rtl/cs_status_reg.sv
// Holds the status word: flag nibble, constant-one bit, stack pointer.
// Assumes DATA_W = FLAG_W + 1 + PTR_W; a direct load wins over engine updates.
module cs_status_reg #(
    parameter int DATA_W = 8,
    parameter int FLAG_W = 4,
    parameter int PTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ptr_inc,
    input  logic              ptr_dec,
    input  logic              flag_ld,
    input  logic [FLAG_W-1:0] flag_data,
    output logic [DATA_W-1:0] status,
    output logic [PTR_W-1:0]  ptr,
    output logic [FLAG_W-1:0] flags
);
    logic [FLAG_W-1:0] flags_q;
    logic [PTR_W-1:0]  ptr_q;

    // Flags and pointer update; pointer wraps modulo its width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            ptr_q   <= '0;
        end else if (wr_en) begin
            flags_q <= wr_data[DATA_W-1 -: FLAG_W];
            ptr_q   <= wr_data[PTR_W-1:0];
        end else begin
            if (ptr_inc)      ptr_q <= ptr_q + PTR_W'(1);
            else if (ptr_dec) ptr_q <= ptr_q - PTR_W'(1);
            if (flag_ld)      flags_q <= flag_data;
        end
    end

    // Read view with the fixed bit forced high.
    always_comb begin
        status = {flags_q, 1'b1, ptr_q};
        ptr    = ptr_q;
        flags  = flags_q;
    end
endmodule

// File: rtl/cs_seq.sv
// Sequences pushes (two writes) and returns (two reads, one capture cycle).
// Assumes RAM read data arrives one cycle after the read strobe.
module cs_seq
    import callret_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int DATA_W = 8,
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              ret_plain_req,
    input  logic              ret_flags_req,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              ready,
    output logic              done,
    output logic [PC_W-1:0]   pc_out,
    output logic              ptr_inc,
    output logic              ptr_dec,
    output logic              flag_ld,
    output logic [FLAG_W-1:0] flag_data,
    output logic              ram_we,
    output logic              ram_re,
    output logic              sel_hi,
    output logic [DATA_W-1:0] ram_wdata
);
    localparam int PC_HI_W = PC_W - DATA_W;

    seq_state_t        state_q;
    logic [PC_W-1:0]   pc_q;
    logic [FLAG_W-1:0] flags_q;
    logic              restore_q;
    logic [DATA_W-1:0] hi_q;
    logic              done_q;
    logic [PC_W-1:0]   pc_out_q;
    logic              acc_call;
    logic              acc_ret;

    // Acceptance: only when idle; a call outranks a return.
    always_comb begin
        ready    = (state_q == ST_IDLE);
        acc_call = ready && call_req;
        acc_ret  = ready && !call_req && (ret_plain_req || ret_flags_req);
    end

    // State, operand capture and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pc_q      <= '0;
            flags_q   <= '0;
            restore_q <= 1'b0;
            hi_q      <= '0;
            done_q    <= 1'b0;
            pc_out_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (acc_call) begin
                        pc_q    <= pc_in;
                        flags_q <= flags_in;
                        state_q <= ST_PUSH_LO;
                    end else if (acc_ret) begin
                        restore_q <= ret_flags_req;
                        state_q   <= ST_RD_HI;
                    end
                end
                ST_PUSH_LO: state_q <= ST_PUSH_HI;
                ST_PUSH_HI: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_RD_HI:   state_q <= ST_RD_LO;
                ST_RD_LO: begin
                    hi_q    <= ram_rdata;
                    state_q <= ST_RD_FIN;
                end
                ST_RD_FIN: begin
                    pc_out_q <= {hi_q[PC_HI_W-1:0], ram_rdata};
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // RAM strobes, pointer moves and flag restore per state.
    always_comb begin
        ram_we    = (state_q == ST_PUSH_LO) || (state_q == ST_PUSH_HI);
        ram_re    = (state_q == ST_RD_HI) || (state_q == ST_RD_LO);
        sel_hi    = (state_q == ST_PUSH_HI) || (state_q == ST_RD_HI);
        ram_wdata = (state_q == ST_PUSH_HI) ? {flags_q, pc_q[PC_W-1:DATA_W]}
                                            : pc_q[DATA_W-1:0];
        ptr_inc   = (state_q == ST_PUSH_HI);
        ptr_dec   = acc_ret;
        flag_ld   = (state_q == ST_RD_FIN) && restore_q;
        flag_data = hi_q[DATA_W-1 -: FLAG_W];
        done      = done_q;
        pc_out    = pc_out_q;
    end
endmodule

// File: rtl/callret_stack.sv
// Top of the return-stack engine: status word, frame addressing, sequencer.
// Assumes one request at a time and a single-port RAM with one-cycle reads.
module callret_stack #(
    parameter int          PC_W       = 12,
    parameter int          DATA_W     = 8,
    parameter int          ADDR_W     = 8,
    parameter int          PTR_W      = 3,
    parameter logic [7:0]  STACK_BASE = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              ret_plain_req,
    input  logic              ret_flags_req,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              sts_we,
    input  logic [DATA_W-1:0] sts_wdata,
    output logic [DATA_W-1:0] status_out,
    output logic              ready,
    output logic              done,
    output logic [PC_W-1:0]   pc_out,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic              ram_re,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    localparam int FLAG_W = DATA_W - 1 - PTR_W;

    logic              sts_load;
    logic              ptr_inc;
    logic              ptr_dec;
    logic              flag_ld;
    logic [FLAG_W-1:0] flag_data;
    logic [PTR_W-1:0]  ptr;
    logic [FLAG_W-1:0] flags;
    logic [ADDR_W-1:0] lo_addr;
    logic [ADDR_W-1:0] hi_addr;
    logic              sel_hi;

    // Direct status load only when idle and nothing else is requested.
    always_comb begin
        sts_load = sts_we && ready && !call_req && !ret_plain_req && !ret_flags_req;
        ram_addr = sel_hi ? hi_addr : lo_addr;
    end

    cs_status_reg #(
        .DATA_W (DATA_W),
        .FLAG_W (FLAG_W),
        .PTR_W  (PTR_W)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sts_load),
        .wr_data   (sts_wdata),
        .ptr_inc   (ptr_inc),
        .ptr_dec   (ptr_dec),
        .flag_ld   (flag_ld),
        .flag_data (flag_data),
        .status    (status_out),
        .ptr       (ptr),
        .flags     (flags)
    );

    cs_frame_addr #(
        .ADDR_W     (ADDR_W),
        .PTR_W      (PTR_W),
        .STACK_BASE (STACK_BASE)
    ) u_addr (
        .ptr     (ptr),
        .lo_addr (lo_addr),
        .hi_addr (hi_addr)
    );

    cs_seq #(
        .PC_W   (PC_W),
        .DATA_W (DATA_W),
        .FLAG_W (FLAG_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .call_req      (call_req),
        .ret_plain_req (ret_plain_req),
        .ret_flags_req (ret_flags_req),
        .pc_in         (pc_in),
        .flags_in      (flags),
        .ram_rdata     (ram_rdata),
        .ready         (ready),
        .done          (done),
        .pc_out        (pc_out),
        .ptr_inc       (ptr_inc),
        .ptr_dec       (ptr_dec),
        .flag_ld       (flag_ld),
        .flag_data     (flag_data),
        .ram_we        (ram_we),
        .ram_re        (ram_re),
        .sel_hi        (sel_hi),
        .ram_wdata     (ram_wdata)
    );
endmodule

// File: rtl/callret_stack_chk.sv
// Port-level protocol checks for the return-stack engine, bound to the top.
// Assumes the default 8-bit status word with a 3-bit pointer.
module callret_stack_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic       done,
    input logic       ram_we,
    input logic       ram_re,
    input logic [7:0] ram_addr,
    input logic [7:0] status_out
);
    AST_FIXED_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        status_out[3]); // R2

    AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |-> (ram_addr >= 8'h08 && ram_addr <= 8'h17)); // R12

    AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !ram_addr[0]) |=> (ram_we && ram_addr == 8'($past(ram_addr) + 8'd1))); // R4

    AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr[0]) |=> (done && status_out[2:0] == 3'($past(status_out[2:0]) + 3'd1))); // R5

    AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_re && ram_addr[0]) |=> (ram_re && ram_addr == 8'($past(ram_addr) - 8'd1))); // R8

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |-> !ready); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ready && !ram_we && !ram_re)); // R10
endmodule

bind callret_stack callret_stack_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .done       (done),
    .ram_we     (ram_we),
    .ram_re     (ram_re),
    .ram_addr   (ram_addr),
    .status_out (status_out)
);

// File: tb/callret_stack_bench.sv
// Directed bench for the return-stack engine; models the RAM itself.
module callret_stack_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 1'b0;
    logic        ret_plain_req = 1'b0;
    logic        ret_flags_req = 1'b0;
    logic [11:0] pc_in = '0;
    logic        sts_we = 1'b0;
    logic [7:0]  sts_wdata = '0;
    logic [7:0]  status_out;
    logic        ready;
    logic        done;
    logic [11:0] pc_out;
    logic [7:0]  ram_addr;
    logic        ram_we;
    logic        ram_re;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;
    logic [7:0]  mem [0:255];

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    callret_stack u_callret_stack (
        .clk           (clk),
        .rst_n         (rst_n),
        .call_req      (call_req),
        .ret_plain_req (ret_plain_req),
        .ret_flags_req (ret_flags_req),
        .pc_in         (pc_in),
        .sts_we        (sts_we),
        .sts_wdata     (sts_wdata),
        .status_out    (status_out),
        .ready         (ready),
        .done          (done),
        .pc_out        (pc_out),
        .ram_addr      (ram_addr),
        .ram_we        (ram_we),
        .ram_re        (ram_re),
        .ram_wdata     (ram_wdata),
        .ram_rdata     (ram_rdata)
    );

    // Bench RAM: synchronous write, one-cycle read latency.
    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr];
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !finished) begin
            n_fail  = n_fail + 1;
            n_tests = n_tests + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", 32'(status_out), 32'h08);
        chk("R1 ready/done/we/re", {28'd0, ready, done, ram_we, ram_re}, 32'b1000);
        chk("R2 fixed bit", 32'(status_out[3]), 32'd1);
    endtask

    task automatic t_sts_write(input logic [7:0] val, input logic [7:0] exp);
        sts_we = 1'b1; sts_wdata = val;
        @(negedge clk);
        sts_we = 1'b0;
        chk("R3 status load", 32'(status_out), 32'(exp));
    endtask

    // Push: writes in cycles 1 and 2, done and pointer step in cycle 3.
    task automatic t_push(input logic [11:0] pc, input string req);
        logic [2:0] p;
        logic [3:0] f;
        logic [7:0] lo;
        p = status_out[2:0];
        f = status_out[7:4];
        lo = 8'h08 + {4'd0, p, 1'b0};
        call_req = 1'b1; pc_in = pc;
        @(negedge clk);
        call_req = 1'b0;
        chk({req, " R4 lo write"}, {15'd0, ram_we, ram_addr, ram_wdata}, {15'd0, 1'b1, lo, pc[7:0]});
        chk("R10 busy", 32'(ready), 32'd0);
        @(negedge clk);
        chk({req, " R4 R6 hi write"}, {15'd0, ram_we, ram_addr, ram_wdata},
            {15'd0, 1'b1, 8'(lo + 8'd1), f, pc[11:8]});
        @(negedge clk);
        chk({req, " R5 done ptr"}, {23'd0, done, status_out},
            {23'd0, 1'b1, f, 1'b1, 3'(p + 3'd1)});
    endtask

    // Return: reads in cycles 1 and 2, done with pc in cycle 4.
    task automatic t_pop(input bit restore, input logic [11:0] exp_pc,
                         input logic [7:0] exp_sts, input string req);
        logic [2:0] p;
        logic [7:0] lo;
        p = status_out[2:0] - 3'd1;
        lo = 8'h08 + {4'd0, p, 1'b0};
        if (restore) ret_flags_req = 1'b1; else ret_plain_req = 1'b1;
        @(negedge clk);
        ret_flags_req = 1'b0; ret_plain_req = 1'b0;
        chk({req, " R8 hi read"}, {23'd0, ram_re, ram_addr}, {23'd0, 1'b1, 8'(lo + 8'd1)});
        @(negedge clk);
        chk({req, " R8 lo read"}, {23'd0, ram_re, ram_addr}, {23'd0, 1'b1, lo});
        @(negedge clk);
        @(negedge clk);
        chk({req, " R8 done pc"}, {19'd0, done, pc_out}, {19'd0, 1'b1, exp_pc});
        chk({req, " R9 status"}, 32'(status_out), 32'(exp_sts));
    endtask

    // Busy: stray requests and status loads during a push are dropped.
    task automatic t_busy();
        call_req = 1'b1; pc_in = 12'h777;
        @(negedge clk);
        call_req = 1'b0;
        ret_flags_req = 1'b1; sts_we = 1'b1; sts_wdata = 8'hF7;
        @(negedge clk);
        ret_flags_req = 1'b0; sts_we = 1'b0;
        @(negedge clk);
        chk("R10 stray ignored", {23'd0, done, status_out}, {23'd0, 1'b1, 8'h09});
        @(negedge clk);
        chk("R10 no read after", {30'd0, ram_re, done}, 32'd0);
    endtask

    // Priority: call and return together perform only the call.
    task automatic t_prio();
        call_req = 1'b1; ret_plain_req = 1'b1; pc_in = 12'h3C5;
        @(negedge clk);
        call_req = 1'b0; ret_plain_req = 1'b0;
        chk("R11 call wins", {22'd0, ram_we, ram_re, ram_addr}, {22'd0, 1'b1, 1'b0, 8'h0A});
        @(negedge clk);
        @(negedge clk);
        chk("R11 ptr up", 32'(status_out), 32'h0A);
    endtask

    initial begin
        t_reset();
        t_sts_write(8'hA5, 8'hAD);
        t_sts_write(8'h30, 8'h38);
        t_push(12'h5A3, "frame0");
        chk("R6 ram hi", 32'(mem[8'h09]), 32'h35);
        t_sts_write(8'hC1, 8'hC9);
        t_push(12'hF12, "frame1");
        t_pop(1'b0, 12'hF12, 8'hC9, "plain");
        t_sts_write(8'h01, 8'h09);
        t_pop(1'b1, 12'h5A3, 8'h38, "restore");
        t_sts_write(8'h00, 8'h08);
        for (int i = 0; i < 8; i++) t_push(12'h100 + 12'(i), "fill");
        chk("R7 wrapped ptr", 32'(status_out), 32'h08);
        chk("R7 top frame", {16'd0, mem[8'h17], mem[8'h16]}, 32'h0107);
        t_push(12'h456, "R7 ninth");
        chk("R7 overwrite", {16'd0, mem[8'h09], mem[8'h08]}, 32'h0456);
        t_pop(1'b0, 12'h456, 8'h08, "after wrap");
        t_busy();
        t_prio();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule